// File: doc/BRIEF.md
# NAND Segment ECC Accumulator

This block builds a 22-bit Hamming-style check code over a 256-byte segment of NAND data while the bytes pass through the controller's data window. Each accepted byte updates two groups of parity. Column parity is taken over bit positions within the byte. Line parity is taken over the byte's index inside the segment. Host software reads the code out as three byte registers, or as one packed word, and does the error correction itself.

A host write to the control offset controls accumulation. One bit enables it, one bit is a one-shot clear, and one bit selects whether the stored code is inverted. In the inverted form an erased (all-ones) segment reads back as all ones. An internal byte counter tracks the column within the segment. Once 256 bytes have been taken the counter wraps to zero and accumulation freezes until the next clear, so trailing spare-area bytes cannot disturb the code.

Top module: `ecc_seg_acc`

## Requirements
- R1: After reset, accumulation is disabled, the invert mode is on, the code is zero and the counter is 0, so all three code bytes read 0xFF and `col_cnt` reads 0.
- R2: A write with `reg_addr` equal to 5 loads the control. Bit 0 enables accumulation, bit 1 clears the code for that cycle only, and bit 2 selects the inverted form. A write to any other offset changes nothing.
- R3: Line parity: for each index bit k (0..7), the odd term is the XOR of the parities of bytes whose index has bit k set, and the even term covers bytes whose index has bit k clear. `ecc_line_lo` holds k=0..3 and `ecc_line_hi` holds k=4..7. Within each register, even[k] sits at bit 2(k mod 4) and odd[k] sits at the bit above it.
- R4: Column parity: `ecc_col` bits 7..2 hold, in that order, the XOR over the segment of bits {4,5,6,7}, {0,1,2,3}, {2,3,6,7}, {0,1,4,5}, {1,3,5,7} and {0,2,4,6}. Bits 1..0 are constant.
- R5: With the invert mode on, every bit of all three code bytes, including the two constant bits, reads as the complement of the raw value. With it off, the raw value is shown and `ecc_col[1:0]` reads 0.
- R6: A byte is accumulated only when `dat_vld` is high and accumulation is enabled. Otherwise the code and the counter hold.
- R7: `col_cnt` counts accepted bytes. It wraps from 255 to 0 and then freezes the code and the counter until a clear.
- R8: A clear zeroes the code, the counter and the freeze. A data byte presented in the same cycle as a clear is discarded.
- R9: `ecc_word` is {`ecc_col`, `ecc_line_lo`, `ecc_line_hi`}, from bit 23 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dat_vld | input | 1 | Data-window byte transfer strobe |
| dat_byte | input | 8 | Byte being transferred |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Register offset within the code window |
| reg_wdata | input | 8 | Host write data |
| ecc_line_lo | output | 8 | Line parity for index bits 0..3 |
| ecc_line_hi | output | 8 | Line parity for index bits 4..7 |
| ecc_col | output | 8 | Column parity byte |
| ecc_word | output | 24 | Packed code for a wide read |
| col_cnt | output | 8 | Byte position within the segment |

## Verification
A wrong parity term or a misplaced bit shows up as a mismatched code byte after the last byte of a segment. A single-byte segment at a chosen index isolates each line term and each column term. A counter that misses a step or wraps early shows up in `col_cnt` on the cycle after the offending byte. It also shows up one segment later as frozen or corrupted code bits. A faulty clear or enable shows in the next sampled `col_cnt` and in the final code.

// File: rtl/ecc_seg_pkg.sv
package ecc_seg_pkg;

    localparam int BYTE_W  = 8;
    localparam int COL_W   = 6;
    localparam int EN_BIT  = 0;
    localparam int CLR_BIT = 1;
    localparam int INV_BIT = 2;

    typedef struct packed {
        logic inv;
        logic clr;
        logic en;
    } ecc_ctl_t;

    // Six column-parity terms of one byte, highest term first.
    function automatic logic [COL_W-1:0] col_terms(input logic [BYTE_W-1:0] b);
        logic [COL_W-1:0] t;
        t[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
        t[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
        t[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
        t[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
        t[4] = b[0] ^ b[1] ^ b[2] ^ b[3];
        t[5] = b[4] ^ b[5] ^ b[6] ^ b[7];
        return t;
    endfunction

endpackage

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
    import ecc_seg_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int CTL_OFS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output ecc_ctl_t          ctl
);

    logic hit;
    logic en_q;
    logic inv_q;

    assign hit = wr && (addr == ADDR_W'(CTL_OFS));

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            inv_q <= 1'b1;
        end else if (hit) begin
            en_q  <= wdata[EN_BIT];
            inv_q <= wdata[INV_BIT];
        end
    end

    assign ctl.en  = en_q;
    assign ctl.inv = inv_q;
    assign ctl.clr = hit && wdata[CLR_BIT];

    // R2
    other_ofs_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> ($stable(en_q) && $stable(inv_q)));

endmodule

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc
    import ecc_seg_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              vld,
    input  logic [BYTE_W-1:0] din,
    output logic [IDX_W-1:0]  lp_odd,
    output logic [IDX_W-1:0]  lp_even,
    output logic [COL_W-1:0]  cp,
    output logic [IDX_W-1:0]  cnt,
    output logic              full
);

    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

    logic accept;
    logic bpar;

    assign accept = en && vld && !full && !clr;
    assign bpar   = ^din;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lp_odd  <= '0;
            lp_even <= '0;
            cp      <= '0;
            cnt     <= '0;
            full    <= 1'b0;
        end else if (accept) begin
            lp_odd  <= lp_odd  ^ ({IDX_W{bpar}} &  cnt);
            lp_even <= lp_even ^ ({IDX_W{bpar}} & ~cnt);
            cp      <= cp ^ col_terms(din);
            cnt     <= cnt + 1'b1;
            if (cnt == LAST) full <= 1'b1;
        end
    end

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (cnt == $past(cnt) + 1'b1));

    // R7
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> ($stable(lp_odd) && $stable(lp_even) && $stable(cp) && cnt == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(en && vld) && !clr) |=> ($stable(cnt) && $stable(cp)));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && !full && cp == '0 && lp_odd == '0 && lp_even == '0));

endmodule

// File: rtl/ecc_seg_acc.sv
module ecc_seg_acc
    import ecc_seg_pkg::*;
#(
    parameter int SEG_BYTES = 256,
    parameter int ADDR_W    = 4,
    parameter int CTL_OFS   = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      dat_vld,
    input  logic [7:0]                dat_byte,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [7:0]                reg_wdata,
    output logic [$clog2(SEG_BYTES)-1:0]     ecc_line_lo,
    output logic [$clog2(SEG_BYTES)-1:0]     ecc_line_hi,
    output logic [7:0]                ecc_col,
    output logic [2*$clog2(SEG_BYTES)+7:0]   ecc_word,
    output logic [$clog2(SEG_BYTES)-1:0]     col_cnt
);

    localparam int IDX_W  = $clog2(SEG_BYTES);
    localparam int LINE_W = 2 * IDX_W;

    ecc_ctl_t          ctl;
    logic [IDX_W-1:0]  lp_odd;
    logic [IDX_W-1:0]  lp_even;
    logic [COL_W-1:0]  cp;
    logic              full;
    logic [LINE_W-1:0] line_raw;
    logic [LINE_W-1:0] line_out;

    ecc_ctl_regs #(.ADDR_W(ADDR_W), .CTL_OFS(CTL_OFS)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctl   (ctl)
    );

    ecc_parity_acc #(.IDX_W(IDX_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.clr),
        .en      (ctl.en),
        .vld     (dat_vld),
        .din     (dat_byte),
        .lp_odd  (lp_odd),
        .lp_even (lp_even),
        .cp      (cp),
        .cnt     (col_cnt),
        .full    (full)
    );

    // Interleave even/odd line terms: even at 2k, odd at 2k+1.
    for (genvar k = 0; k < IDX_W; k++) begin : g_line
        assign line_raw[2*k]   = lp_even[k];
        assign line_raw[2*k+1] = lp_odd[k];
    end

    assign line_out    = line_raw ^ {LINE_W{ctl.inv}};
    assign ecc_line_lo = line_out[IDX_W-1:0];
    assign ecc_line_hi = line_out[LINE_W-1:IDX_W];
    assign ecc_col     = {cp, 2'b00} ^ {8{ctl.inv}};
    assign ecc_word    = {ecc_col, ecc_line_lo, ecc_line_hi};

    // R5
    col_pad_chk: assert property (@(posedge clk) disable iff (rst)
        ecc_col[1:0] == {2{ctl.inv}});

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> (col_cnt == '0));

endmodule

// File: tb/sim_ecc_seg_acc.sv
module sim_ecc_seg_acc;

    logic        clk = 1'b0;
    logic        rst;
    logic        dat_vld;
    logic [7:0]  dat_byte;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  ecc_line_lo;
    logic [7:0]  ecc_line_hi;
    logic [7:0]  ecc_col;
    logic [23:0] ecc_word;
    logic [7:0]  col_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] pg [256];

    always #2 clk = ~clk;

    ecc_seg_acc u0 (
        .clk(clk), .rst(rst), .dat_vld(dat_vld), .dat_byte(dat_byte),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ecc_line_lo(ecc_line_lo), .ecc_line_hi(ecc_line_hi),
        .ecc_col(ecc_col), .ecc_word(ecc_word), .col_cnt(col_cnt)
    );

    // fill, poke index, poke value, expected packed code (inverted form)
    localparam logic [47:0] VEC [6] = '{
        {8'h00, 8'h00, 8'h00, 24'hFFFFFF},
        {8'hFF, 8'h00, 8'hFF, 24'hFFFFFF},
        {8'h00, 8'h00, 8'h01, 24'hABAAAA},
        {8'h00, 8'hFF, 8'h80, 24'h575555},
        {8'h00, 8'h0F, 8'h03, 24'hF3FFFF},
        {8'h00, 8'hA5, 8'h10, 24'h6B9966}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        dat_vld = 1'b1; dat_byte = d;
        @(negedge clk);
        dat_vld = 1'b0;
    endtask

    task automatic send_page();
        for (int i = 0; i < 256; i++) put(pg[i]);
    endtask

    // Independent model: walk every set bit and toggle the terms it feeds.
    function automatic logic [23:0] model(input logic inv);
        logic [7:0] ev, od;
        logic [2:0] cev, cod;
        logic [15:0] ln;
        logic [7:0] cl;
        ev = '0; od = '0; cev = '0; cod = '0;
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 8; j++)
                if (pg[i][j]) begin
                    for (int k = 0; k < 8; k++)
                        if (i[k]) od[k] = ~od[k]; else ev[k] = ~ev[k];
                    for (int t = 0; t < 3; t++)
                        if (j[t]) cod[t] = ~cod[t]; else cev[t] = ~cev[t];
                end
        for (int k = 0; k < 8; k++) begin
            ln[2*k] = ev[k]; ln[2*k+1] = od[k];
        end
        cl = {cod[2], cev[2], cod[1], cev[1], cod[0], cev[0], 2'b00};
        if (inv) begin ln = ~ln; cl = ~cl; end
        return {cl, ln[7:0], ln[15:8]};
    endfunction

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; dat_vld = 0; dat_byte = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 code", {8'h0, ecc_word}, {8'h0, 24'hFFFFFF});
        chk("R1 cnt", {24'h0, col_cnt}, 32'h0);
        // R6: disabled after reset, bytes ignored
        put(8'h01);
        chk("R6 disabled cnt", {24'h0, col_cnt}, 32'h0);
        chk("R6 disabled code", {8'h0, ecc_word}, {8'h0, 24'hFFFFFF});

        // Table walk (R3 R4 R5 R7 R9)
        for (int v = 0; v < 6; v++) begin
            for (int i = 0; i < 256; i++) pg[i] = VEC[v][47:40];
            pg[VEC[v][39:32]] = VEC[v][31:24];
            wr_reg(4'h5, 8'h07);
            send_page();
            chk("R3 R4 R9 table code", {8'h0, ecc_word}, {8'h0, VEC[v][23:0]});
            chk("R7 wrap cnt", {24'h0, col_cnt}, 32'h0);
        end
        chk("R9 line_hi", {24'h0, ecc_line_hi}, 32'h66);
        chk("R9 line_lo", {24'h0, ecc_line_lo}, 32'h99);
        chk("R4 col", {24'h0, ecc_col}, 32'h6B);

        // R7: frozen after wrap, extra bytes ignored
        put(8'hFE); put(8'h01);
        chk("R7 frozen code", {8'h0, ecc_word}, {8'h0, 24'h6B9966});
        chk("R7 frozen cnt", {24'h0, col_cnt}, 32'h0);

        // R5: raw form of the same segment
        wr_reg(4'h5, 8'h03);
        send_page();
        chk("R5 raw code", {8'h0, ecc_word}, {8'h0, 24'h946699});

        // Pseudo-random segments against the model, both modes (R3 R4 R5)
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 256; i++) pg[i] = 8'((i * (37 + 2*r)) ^ (i >> 3) ^ (r * 91));
            wr_reg(4'h5, (r == 1) ? 8'h03 : 8'h07);
            send_page();
            chk("R3 R4 R5 model", {8'h0, ecc_word}, {8'h0, model(r != 1)});
        end

        // R7: counter progress
        wr_reg(4'h5, 8'h07);
        for (int i = 0; i < 10; i++) put(8'h5A);
        chk("R7 cnt 10", {24'h0, col_cnt}, 32'd10);

        // R2: other offsets ignored (clear and disable attempts)
        wr_reg(4'h4, 8'h02);
        wr_reg(4'h6, 8'h00);
        put(8'h00);
        chk("R2 other offset", {24'h0, col_cnt}, 32'd11);

        // R6: enable off holds counter
        wr_reg(4'h5, 8'h04);
        put(8'h33);
        chk("R6 enable off", {24'h0, col_cnt}, 32'd11);

        // R8: clear with same-cycle byte discarded
        wr_reg(4'h5, 8'h05);
        put(8'h01);
        chk("R8 pre cnt", {24'h0, col_cnt}, 32'd12);
        @(negedge clk);
        reg_wr = 1; reg_addr = 4'h5; reg_wdata = 8'h07; dat_vld = 1; dat_byte = 8'h01;
        @(negedge clk);
        reg_wr = 0; dat_vld = 0;
        chk("R8 clear cnt", {24'h0, col_cnt}, 32'h0);
        chk("R8 clear code", {8'h0, ecc_word}, {8'h0, 24'hFFFFFF});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule